// File: doc/BRIEF.md
# Extended Address and Chip-Select Generator

This block forms the external memory address for an 8-bit core whose address buses are not multiplexed with data. Every cycle it receives the kind of bus access the core is about to make, together with the program counter, the data pointer, the accumulator and the indirect register value. From these it produces a low address byte, a high address byte and a 4-bit top nibble. All outputs are registered, so they hold steady for the whole bus cycle that follows the clock edge.

Two byte-wide special-function registers control the block. The page register supplies the high address byte when the core makes an indirect access through a register. The control register holds a mode bit and a 4-bit bank value. In extended mode the top nibble carries the bank as address bits 19:16, but only for table reads from code space and for data accesses; during an instruction fetch the nibble is zero. In select mode the top nibble becomes four active-low device selects, decoded from address bits 15:14, and each select covers a 16 KB window. Both registers are reached over a simple SFR bus that reads combinationally and writes on the clock edge.

Top module: `xaddr_gen`

## Requirements
- R1: After reset, addr_lo, addr_hi and addr_top are all zero. The page register (0xA1) reads 0x00 and the control register (0xA2) reads 0x70.
- R2: The control register sits at SFR address 0xA2. Bit 7 is the mode (0 = extended, 1 = select) and bits 3:0 are the bank. Bits 6:4 always read 111b, whatever value was written to them.
- R3: The page register sits at SFR address 0xA1 and reads back the last byte written to it.
- R4: An instruction fetch (acc_type 0) drives {addr_hi, addr_lo} = pc. This appears on the outputs one clock edge after the inputs are sampled.
- R5: A data access through the pointer (acc_type 2) drives addr_hi = dptr[15:8] and addr_lo = dptr[7:0].
- R6: A table read from code space (acc_type 1) drives {addr_hi, addr_lo} = dptr + acc_a, with the sum wrapping modulo 2^16.
- R7: An indirect access through a register (acc_type 3) drives addr_hi from the page register and addr_lo from ri_val.
- R8: In extended mode, addr_top equals the bank for acc_type 1, 2 and 3. It is 0 for a fetch.
- R9: In select mode, addr_top drives bit n low, and only bit n, where n = addr_hi[7:6] of the same output cycle. This holds for every access type.
- R10: For any SFR address other than 0xA1 and 0xA2, sfr_rsel is 0 and sfr_rdata is 0x00. A write to such an address changes no register and no output.
- R11: An SFR write applies at the clock edge that samples it. The outputs registered at that same edge still use the old register values; the new values appear from the next access onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_type | input | 2 | Access kind: 0 fetch, 1 code table read, 2 pointer data, 3 register-indirect data |
| pc | input | 16 | Program counter |
| dptr | input | 16 | Data pointer |
| acc_a | input | 8 | Accumulator, used as the offset for table reads |
| ri_val | input | 8 | Indirect register value |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, 0 when not selected |
| sfr_rsel | output | 1 | High when sfr_addr belongs to this block |
| addr_lo | output | 8 | Address bits 7:0 |
| addr_hi | output | 8 | Address bits 15:8 |
| addr_top | output | 4 | Address bits 19:16, or active-low selects |

## Verification
The bench aims at the corner cases that break silently:
- A fetch made in extended mode with a non-zero bank. A design that forwarded the bank here would run code from the wrong bank.
- A table read whose accumulator offset carries into the high byte, or wraps past 0xFFFF. A design that concatenated instead of adding would put out the wrong high byte.
- A select-mode sweep over all four quarters, including register-indirect accesses where the page register picks the select. A design that decoded the wrong bits, or left more than one line low, would enable two devices at once.
- An SFR write issued in the same cycle as an access. A design with the wrong latency would update the address one cycle early.
- Attempts to write the reserved bits and writes to foreign addresses. These must leave both the readback and the outputs unchanged.

// File: rtl/xaddr_pkg.sv
package xaddr_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_CODE  = 2'd1,
    ACC_DPTR  = 2'd2,
    ACC_RI    = 2'd3
  } acc_e;

  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int SEL_BITS = 2;
  localparam int TOP_W    = 1 << SEL_BITS;

  // table-read address: base plus unsigned byte offset, wrapping at 16 bits
  function automatic logic [WORD_W-1:0] table_addr(input logic [WORD_W-1:0] base,
                                                   input logic [BYTE_W-1:0] ofs);
    return base + {{(WORD_W-BYTE_W){1'b0}}, ofs};
  endfunction

  // active-low one-hot select for a window index
  function automatic logic [TOP_W-1:0] sel_decode(input logic [SEL_BITS-1:0] idx);
    logic [TOP_W-1:0] v;
    v = '1;
    v[idx] = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/xaddr_sfr_regs.sv
module xaddr_sfr_regs
  import xaddr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PAGE_ADDR = 8'hA1,
  parameter logic [BYTE_W-1:0] CTRL_ADDR = 8'hA2,
  parameter logic [BYTE_W-1:0] PAGE_RST  = 8'h00,
  parameter logic [TOP_W-1:0]  BANK_RST  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [BYTE_W-1:0] sfr_wdata,
  output logic [BYTE_W-1:0] sfr_rdata,
  output logic              sfr_rsel,
  output logic [BYTE_W-1:0] page_q,
  output logic              cs_mode,
  output logic [TOP_W-1:0]  bank_q
);

  localparam int RSV_W = BYTE_W - 1 - TOP_W;

  logic hit_page, hit_ctrl;
  assign hit_page = (sfr_addr == PAGE_ADDR);
  assign hit_ctrl = (sfr_addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= PAGE_RST;
      cs_mode <= 1'b0;
      bank_q  <= BANK_RST;
    end else if (sfr_wr) begin
      if (hit_page) page_q <= sfr_wdata;
      if (hit_ctrl) begin
        cs_mode <= sfr_wdata[BYTE_W-1];
        bank_q  <= sfr_wdata[TOP_W-1:0];
      end
    end
  end

  always_comb begin
    sfr_rsel  = hit_page | hit_ctrl;
    sfr_rdata = '0;
    if (hit_page) sfr_rdata = page_q;
    else if (hit_ctrl) sfr_rdata = {cs_mode, {RSV_W{1'b1}}, bank_q};
  end

endmodule

// File: rtl/xaddr_mux.sv
module xaddr_mux
  import xaddr_pkg::*;
(
  input  acc_e              acc,
  input  logic [WORD_W-1:0] pc,
  input  logic [WORD_W-1:0] dptr,
  input  logic [BYTE_W-1:0] acc_a,
  input  logic [BYTE_W-1:0] ri_val,
  input  logic [BYTE_W-1:0] page,
  output logic [BYTE_W-1:0] hi,
  output logic [BYTE_W-1:0] lo,
  output logic              ext_cycle
);

  logic [WORD_W-1:0] word;

  always_comb begin
    unique case (acc)
      ACC_FETCH: word = pc;
      ACC_CODE:  word = table_addr(dptr, acc_a);
      ACC_DPTR:  word = dptr;
      default:   word = {page, ri_val};
    endcase
  end

  assign hi        = word[WORD_W-1:BYTE_W];
  assign lo        = word[BYTE_W-1:0];
  assign ext_cycle = (acc != ACC_FETCH);

endmodule

// File: rtl/xaddr_nibble.sv
module xaddr_nibble
  import xaddr_pkg::*;
(
  input  logic                cs_mode,
  input  logic                ext_cycle,
  input  logic [TOP_W-1:0]    bank,
  input  logic [SEL_BITS-1:0] win,
  output logic [TOP_W-1:0]    top
);

  logic [TOP_W-1:0] sel_n;
  assign sel_n = sel_decode(win);

  for (genvar i = 0; i < TOP_W; i++) begin : g_bit
    assign top[i] = cs_mode ? sel_n[i] : (ext_cycle & bank[i]);
  end

endmodule

// File: rtl/xaddr_gen.sv
module xaddr_gen
  import xaddr_pkg::*;
#(
  parameter logic [7:0] PAGE_ADDR = 8'hA1,
  parameter logic [7:0] CTRL_ADDR = 8'hA2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  acc_type,
  input  logic [15:0] pc,
  input  logic [15:0] dptr,
  input  logic [7:0]  acc_a,
  input  logic [7:0]  ri_val,
  input  logic [7:0]  sfr_addr,
  input  logic        sfr_wr,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  output logic        sfr_rsel,
  output logic [7:0]  addr_lo,
  output logic [7:0]  addr_hi,
  output logic [3:0]  addr_top
);

  acc_e             acc_in;
  logic [BYTE_W-1:0] page_q;
  logic              cs_mode;
  logic [TOP_W-1:0]  bank_q;
  logic [BYTE_W-1:0] hi_d, lo_d;
  logic              ext_cycle;
  logic [TOP_W-1:0]  top_d;

  // named state of the cycle currently on the outputs, for the checker
  acc_e out_acc;
  logic top_is_cs;

  assign acc_in = acc_e'(acc_type);

  xaddr_sfr_regs #(
    .PAGE_ADDR(PAGE_ADDR),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sfr_addr (sfr_addr),
    .sfr_wr   (sfr_wr),
    .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata),
    .sfr_rsel (sfr_rsel),
    .page_q   (page_q),
    .cs_mode  (cs_mode),
    .bank_q   (bank_q)
  );

  xaddr_mux u_mux (
    .acc      (acc_in),
    .pc       (pc),
    .dptr     (dptr),
    .acc_a    (acc_a),
    .ri_val   (ri_val),
    .page     (page_q),
    .hi       (hi_d),
    .lo       (lo_d),
    .ext_cycle(ext_cycle)
  );

  xaddr_nibble u_nib (
    .cs_mode  (cs_mode),
    .ext_cycle(ext_cycle),
    .bank     (bank_q),
    .win      (hi_d[BYTE_W-1 -: SEL_BITS]),
    .top      (top_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo   <= '0;
      addr_hi   <= '0;
      addr_top  <= '0;
      out_acc   <= ACC_FETCH;
      top_is_cs <= 1'b0;
    end else begin
      addr_lo   <= lo_d;
      addr_hi   <= hi_d;
      addr_top  <= top_d;
      out_acc   <= acc_in;
      top_is_cs <= cs_mode;
    end
  end

endmodule

module xaddr_gen_chk
  import xaddr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] dptr,
  input logic [7:0]  sfr_addr,
  input logic        sfr_wr,
  input logic [7:0]  sfr_wdata,
  input logic [7:0]  sfr_rdata,
  input logic        sfr_rsel,
  input logic [7:0]  addr_lo,
  input logic [7:0]  addr_hi,
  input logic [3:0]  addr_top,
  input logic [7:0]  page_q,
  input acc_e        out_acc,
  input logic        top_is_cs
);

  // R9
  cs_one_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_is_cs |-> ($countones(~addr_top) == 1 && addr_top[addr_hi[7:6]] == 1'b0));

  // R8
  fetch_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!top_is_cs && out_acc == ACC_FETCH) |-> addr_top == 4'h0);

  // R5
  dptr_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_acc == ACC_DPTR) |-> {addr_hi, addr_lo} == $past(dptr));

  // R3
  page_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == 8'hA1) |=> page_q == $past(sfr_wdata));

  // R2
  ctrl_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == 8'hA2) |-> (sfr_rsel && sfr_rdata[6:4] == 3'b111));

  // R10
  foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr != 8'hA1 && sfr_addr != 8'hA2) |-> (!sfr_rsel && sfr_rdata == 8'h00));

  // R7
  ri_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_acc == ACC_RI && $stable(page_q)) |-> addr_hi == page_q);

endmodule

bind xaddr_gen xaddr_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dptr     (dptr),
  .sfr_addr (sfr_addr),
  .sfr_wr   (sfr_wr),
  .sfr_wdata(sfr_wdata),
  .sfr_rdata(sfr_rdata),
  .sfr_rsel (sfr_rsel),
  .addr_lo  (addr_lo),
  .addr_hi  (addr_hi),
  .addr_top (addr_top),
  .page_q   (page_q),
  .out_acc  (out_acc),
  .top_is_cs(top_is_cs)
);

// File: tb/xaddr_gen_tb.sv
module xaddr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  acc_type = 2'd0;
  logic [15:0] pc = '0, dptr = '0;
  logic [7:0]  acc_a = '0, ri_val = '0, sfr_addr = '0, sfr_wdata = '0;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_rdata, addr_lo, addr_hi;
  logic        sfr_rsel;
  logic [3:0]  addr_top;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] lo;
    logic [7:0] hi;
    logic [3:0] top;
    string      tag;
  } exp_t;
  exp_t q[$];

  // reference state
  logic [7:0] m_page = 8'h00;
  logic       m_cs = 1'b0;
  logic [3:0] m_bank = 4'h0;

  always #5 clk = ~clk;

  xaddr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .acc_type(acc_type), .pc(pc), .dptr(dptr),
    .acc_a(acc_a), .ri_val(ri_val), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_rsel(sfr_rsel),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .addr_top(addr_top)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: applies one access (with optional SFR write) and queues the expected address
  task automatic step(input logic [1:0] acc, input logic [15:0] p, input logic [15:0] d,
                      input logic [7:0] a, input logic [7:0] r,
                      input bit wr, input logic [7:0] wa, input logic [7:0] wd, input string tag);
    exp_t e;
    logic [15:0] w;
    @(negedge clk);
    acc_type = acc; pc = p; dptr = d; acc_a = a; ri_val = r;
    sfr_wr = wr; sfr_addr = wa; sfr_wdata = wd;
    case (acc)
      2'd0: w = p;
      2'd1: w = d + 16'(a);
      2'd2: w = d;
      default: w = {m_page, r};
    endcase
    e.hi = w[15:8]; e.lo = w[7:0]; e.tag = tag;
    if (m_cs) e.top = ~(4'b0001 << w[15:14]);
    else e.top = (acc != 2'd0) ? m_bank : 4'h0;
    q.push_back(e);
    if (wr && wa == 8'hA1) m_page = wd;
    if (wr && wa == 8'hA2) begin m_cs = wd[7]; m_bank = wd[3:0]; end
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input bit sel, input string tag);
    @(negedge clk);
    sfr_wr = 1'b0; sfr_addr = a;
    #1;
    check(sfr_rdata == exp && sfr_rsel == sel, tag, {23'd0, sfr_rsel, sfr_rdata}, {23'd0, sel, exp});
  endtask

  // monitor
  always @(posedge clk) begin
    #3;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({addr_top, addr_hi, addr_lo} == {e.top, e.hi, e.lo}, e.tag,
            {12'd0, addr_top, addr_hi, addr_lo}, {12'd0, e.top, e.hi, e.lo});
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check({addr_top, addr_hi, addr_lo} == 20'h0, "R1 outputs in reset", {addr_top, addr_hi, addr_lo}, 0);
    rst_n = 1'b1;
    rd(8'hA1, 8'h00, 1'b1, "R1 page reset");
    rd(8'hA2, 8'h70, 1'b1, "R1 ctrl reset");

    // basic routing, extended mode, bank 0
    step(2'd0, 16'h1234, 16'h0000, 8'h00, 8'h00, 0, 8'h00, 8'h00, "R4 fetch");
    step(2'd2, 16'h1234, 16'hBEEF, 8'h00, 8'h00, 0, 8'h00, 8'h00, "R5 dptr");
    step(2'd1, 16'h1234, 16'h12F0, 8'h20, 8'h00, 0, 8'h00, 8'h00, "R6 table carry");
    step(2'd1, 16'h1234, 16'hFFF0, 8'h15, 8'h00, 0, 8'h00, 8'h00, "R6 table wrap");
    step(2'd3, 16'h1234, 16'h0000, 8'h00, 8'h5A, 0, 8'h00, 8'h00, "R7 ri page0");

    // write page 0x12 in same cycle as a ri access: old page still used (R11)
    step(2'd3, 16'h0000, 16'h0000, 8'h00, 8'h33, 1, 8'hA1, 8'h12, "R11 page write latency");
    step(2'd3, 16'h0000, 16'h0000, 8'h00, 8'h34, 0, 8'h00, 8'h00, "R7 ri new page");
    rd(8'hA1, 8'h12, 1'b1, "R3 page readback");

    // bank 5, reserved bits written zero (R2)
    step(2'd2, 16'h0000, 16'h4000, 8'h00, 8'h00, 1, 8'hA2, 8'h05, "R11 ctrl write latency");
    rd(8'hA2, 8'h75, 1'b1, "R2 reserved read as ones");
    step(2'd0, 16'hABCD, 16'h4000, 8'h00, 8'h00, 0, 8'h00, 8'h00, "R8 fetch top zero");
    step(2'd2, 16'hABCD, 16'h4000, 8'h00, 8'h00, 0, 8'h00, 8'h00, "R8 dptr bank");
    step(2'd1, 16'hABCD, 16'h0100, 8'h01, 8'h00, 0, 8'h00, 8'h00, "R8 table bank");
    step(2'd3, 16'hABCD, 16'h0000, 8'h00, 8'h99, 0, 8'h00, 8'h00, "R8 ri bank");

    // foreign writes ignored (R10)
    step(2'd0, 16'h0000, 16'h0000, 8'h00, 8'h00, 1, 8'hA3, 8'h8F, "R10 foreign write");
    step(2'd2, 16'h0000, 16'h0102, 8'h00, 8'h00, 1, 8'hA0, 8'hFF, "R10 foreign write 2");
    step(2'd3, 16'h0000, 16'h0000, 8'h00, 8'h01, 0, 8'h00, 8'h00, "R10 outputs unchanged");
    rd(8'hA3, 8'h00, 1'b0, "R10 foreign read");
    rd(8'hA1, 8'h12, 1'b1, "R10 page kept");
    rd(8'hA2, 8'h75, 1'b1, "R10 ctrl kept");

    // select mode, bank F
    step(2'd0, 16'h0000, 16'h0000, 8'h00, 8'h00, 1, 8'hA2, 8'h8F, "R11 enter select");
    rd(8'hA2, 8'hFF, 1'b1, "R2 select mode readback");
    for (int i = 0; i < 4; i++) begin
      step(2'd0, 16'(i) << 14 | 16'h0123, 16'h0000, 8'h00, 8'h00, 0, 8'h00, 8'h00, "R9 fetch window");
      step(2'd2, 16'h0000, 16'(3 - i) << 14 | 16'h3FFF, 8'h00, 8'h00, 0, 8'h00, 8'h00, "R9 dptr window");
    end
    step(2'd1, 16'h0000, 16'h3FFF, 8'h01, 8'h00, 0, 8'h00, 8'h00, "R9 table crosses window");
    step(2'd3, 16'h0000, 16'h0000, 8'h00, 8'h00, 1, 8'hA1, 8'hC7, "R9 ri page 0x12");
    step(2'd3, 16'h0000, 16'h0000, 8'h00, 8'hEE, 0, 8'h00, 8'h00, "R9 ri page 0xC7");

    // back to extended mode, bank 3
    step(2'd0, 16'hFFFF, 16'h0000, 8'h00, 8'h00, 1, 8'hA2, 8'h03, "R9 last select cycle");
    step(2'd0, 16'hFFFF, 16'h0000, 8'h00, 8'h00, 0, 8'h00, 8'h00, "R8 fetch after leave");
    step(2'd2, 16'h0000, 16'hC000, 8'h00, 8'h00, 0, 8'h00, 8'h00, "R8 bank 3");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule